// File: doc/BRIEF.md
# Metadata Address Translation Buffer

This block turns an application data address into the address of the shadow metadata that describes it, in a single combinational step. Shadow metadata is held in a two-level layout. The upper address bits form a region number, and each region owns one level-2 chunk of metadata. The lower address bits, scaled down by the metadata granularity, pick the element inside that chunk. The buffer caches the region-to-chunk step in a small, fully associative table, so a monitoring handler can get the final metadata address without a shift, a mask and an indexed load from the level-1 table.

The table is maintained by software. On a miss, the requester walks its level-1 table itself and installs the chunk base through the fill port. Entries are removed one region at a time through the invalidate port, or all at once through the flush input. Table depth, address width, region size and granularity shift are all parameters. The defaults are 16 entries, 32-bit addresses, 64 KiB regions (region number = address bits 31:16) and a granularity shift of 2 (one metadata byte for every 4 application bytes).

Top module: `meta_xlat_buf`

## Requirements
- R1: After reset, every entry is invalid, so any lookup with lk_en high reports a miss.
- R2: When lk_en is high and lk_addr[31:16] matches a valid entry, lk_hit is 1 in the same cycle and lk_maddr equals that entry's chunk base plus (lk_addr[15:0] >> GRAN_SHIFT).
- R3: When a lookup finds no valid entry, lk_miss is 1, lk_hit is 0 and lk_maddr is 0. When lk_en is low, lk_hit, lk_miss and lk_maddr are all 0.
- R4: A fill applied at a clock edge is visible to lookups from the cycle after that edge.
- R5: A fill to a region already held overwrites that entry's chunk base and uses no other entry, so no region is ever held twice.
- R6: A fill to a new region takes the lowest-numbered invalid entry. Up to 16 distinct regions can be held at once.
- R7: A fill to a new region when all entries are valid replaces the entry at a round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping, only on such a replacement.
- R8: An invalidate clears only the entry holding inv_region. Invalidating a region that is not held has no effect.
- R9: A flush clears every entry and resets the round-robin pointer in one cycle, and it overrides a fill in the same cycle.
- R10: When a fill and an invalidate of the same region occur in the same cycle, the fill wins. The entry choice for a fill is made from the table state before that cycle.
- R11: The granularity shift is a parameter. With GRAN_SHIFT = 3, a hit returns chunk base + (lk_addr[15:0] >> 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_en | input | 1 | Lookup request |
| lk_addr | input | 32 | Application address to translate |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_miss | output | 1 | Lookup found no valid entry |
| lk_maddr | output | 32 | Metadata address on a hit, else 0 |
| fill_en | input | 1 | Install a translation |
| fill_region | input | 16 | Region number (address bits 31:16) to install |
| fill_base | input | 32 | Chunk base address for that region |
| inv_en | input | 1 | Invalidate one region |
| inv_region | input | 16 | Region number to invalidate |
| flush | input | 1 | Clear the whole table |

## Verification
Lookup results are combinational, so each lookup is driven at a falling edge and sampled two nanoseconds later, within the same cycle. Fills, invalidates and flushes are driven at a falling edge and take effect at the next rising edge. The bench therefore updates its own model of the table at that edge and checks lookups only after it. Every lookup is compared against a model that applies the entry-choice rules, and against a second instance built with a granularity shift of 3.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
    typedef enum logic [1:0] {
        FILL_HIT   = 2'd0,
        FILL_FREE  = 2'd1,
        FILL_EVICT = 2'd2
    } fill_kind_e;
endpackage

// File: rtl/mxb_match.sv
module mxb_match #(
    parameter int N  = 16,
    parameter int TW = 16
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][TW-1:0] tags,
    input  logic [TW-1:0]        key,
    output logic [N-1:0]         hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = vld[i] && (tags[i] == key);
    end
endmodule

// File: rtl/mxb_slot_pick.sv
module mxb_slot_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]          match,
    input  logic [N-1:0]          vld,
    input  logic [IW-1:0]         rr,
    output logic [IW-1:0]         idx,
    output mxb_pkg::fill_kind_e   kind
);
    always_comb begin
        idx  = rr;
        kind = mxb_pkg::FILL_EVICT;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                idx  = IW'(i);
                kind = mxb_pkg::FILL_FREE;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                idx  = IW'(i);
                kind = mxb_pkg::FILL_HIT;
            end
        end
    end
endmodule

// File: rtl/mxb_addr_gen.sv
module mxb_addr_gen #(
    parameter int N            = 16,
    parameter int AW           = 32,
    parameter int REGION_SHIFT = 16,
    parameter int GRAN_SHIFT   = 2
) (
    input  logic [N-1:0]               sel,
    input  logic [N-1:0][AW-1:0]       bases,
    input  logic [REGION_SHIFT-1:0]    off,
    output logic [AW-1:0]              maddr
);
    logic [AW-1:0] base_sel;
    logic [REGION_SHIFT-1:0] scaled;

    always_comb begin
        base_sel = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) base_sel = base_sel | bases[i];
        end
        scaled = off >> GRAN_SHIFT;
        maddr  = base_sel + AW'(scaled);
    end
endmodule

// File: rtl/meta_xlat_buf.sv
module meta_xlat_buf #(
    parameter int N            = 16,
    parameter int AW           = 32,
    parameter int REGION_SHIFT = 16,
    parameter int GRAN_SHIFT   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lk_en,
    input  logic [AW-1:0]               lk_addr,
    output logic                        lk_hit,
    output logic                        lk_miss,
    output logic [AW-1:0]               lk_maddr,
    input  logic                        fill_en,
    input  logic [AW-REGION_SHIFT-1:0]  fill_region,
    input  logic [AW-1:0]               fill_base,
    input  logic                        inv_en,
    input  logic [AW-REGION_SHIFT-1:0]  inv_region,
    input  logic                        flush
);
    localparam int TW = AW - REGION_SHIFT;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][TW-1:0] tag;
        logic [N-1:0][AW-1:0] base;
        logic [IW-1:0]        rr;
    } state_t;

    state_t state_q, state_d;

    logic [N-1:0]        lk_match;
    logic [N-1:0]        fill_match;
    logic [N-1:0]        inv_match;
    logic [IW-1:0]       fill_idx;
    mxb_pkg::fill_kind_e fill_kind;
    logic [AW-1:0]       comp_addr;

    mxb_match #(.N(N), .TW(TW)) u_lk_match (
        .vld(state_q.vld), .tags(state_q.tag),
        .key(lk_addr[AW-1:REGION_SHIFT]), .hit(lk_match)
    );

    mxb_match #(.N(N), .TW(TW)) u_fill_match (
        .vld(state_q.vld), .tags(state_q.tag),
        .key(fill_region), .hit(fill_match)
    );

    mxb_match #(.N(N), .TW(TW)) u_inv_match (
        .vld(state_q.vld), .tags(state_q.tag),
        .key(inv_region), .hit(inv_match)
    );

    mxb_slot_pick #(.N(N), .IW(IW)) u_pick (
        .match(fill_match), .vld(state_q.vld), .rr(state_q.rr),
        .idx(fill_idx), .kind(fill_kind)
    );

    mxb_addr_gen #(
        .N(N), .AW(AW), .REGION_SHIFT(REGION_SHIFT), .GRAN_SHIFT(GRAN_SHIFT)
    ) u_addr (
        .sel(lk_match), .bases(state_q.base),
        .off(lk_addr[REGION_SHIFT-1:0]), .maddr(comp_addr)
    );

    always_comb begin
        lk_hit   = lk_en && (|lk_match);
        lk_miss  = lk_en && !(|lk_match);
        lk_maddr = lk_hit ? comp_addr : '0;
    end

    always_comb begin
        state_d = state_q;
        if (inv_en) begin
            state_d.vld = state_q.vld & ~inv_match;
        end
        if (fill_en) begin
            state_d.vld[fill_idx]  = 1'b1;
            state_d.tag[fill_idx]  = fill_region;
            state_d.base[fill_idx] = fill_base;
            if (fill_kind == mxb_pkg::FILL_EVICT) begin
                state_d.rr = (state_q.rr == IW'(N - 1)) ? '0 : state_q.rr + 1'b1;
            end
        end
        if (flush) begin
            state_d.vld = '0;
            state_d.rr  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.vld  <= '0;
            state_q.rr   <= '0;
            state_q.tag  <= '0;
            state_q.base <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/mxb_chk.sv
module mxb_chk #(
    parameter int N            = 16,
    parameter int AW           = 32,
    parameter int REGION_SHIFT = 16,
    parameter int GRAN_SHIFT   = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        lk_en,
    input logic [AW-1:0]               lk_addr,
    input logic                        lk_hit,
    input logic                        lk_miss,
    input logic [AW-1:0]               lk_maddr,
    input logic                        fill_en,
    input logic [AW-REGION_SHIFT-1:0]  fill_region,
    input logic [AW-1:0]               fill_base,
    input logic                        flush,
    input logic [N-1:0]                lk_match
);
    logic [REGION_SHIFT-1:0] off_scaled;
    assign off_scaled = lk_addr[REGION_SHIFT-1:0] >> GRAN_SHIFT;

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_maddr == '0) && !lk_hit);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |-> !lk_hit && !lk_miss && (lk_maddr == '0));

    // R5
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R4
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fill_en && !flush) && lk_en &&
         (lk_addr[AW-1:REGION_SHIFT] == $past(fill_region)))
        |-> lk_hit && (lk_maddr == $past(fill_base) + AW'(off_scaled)));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && lk_en) |-> lk_miss);
endmodule

bind meta_xlat_buf mxb_chk #(
    .N(N), .AW(AW), .REGION_SHIFT(REGION_SHIFT), .GRAN_SHIFT(GRAN_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_maddr(lk_maddr),
    .fill_en(fill_en), .fill_region(fill_region), .fill_base(fill_base),
    .flush(flush), .lk_match(lk_match)
);

// File: tb/meta_xlat_buf_test.sv
`timescale 1ns/1ps
module meta_xlat_buf_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_en = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        fill_en = 1'b0;
    logic [15:0] fill_region = '0;
    logic [31:0] fill_base = '0;
    logic        inv_en = 1'b0;
    logic [15:0] inv_region = '0;
    logic        flush = 1'b0;
    logic        hit2, miss2, hit3, miss3;
    logic [31:0] ma2, ma3;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic        mv [N];
    logic [15:0] mt [N];
    logic [31:0] mb [N];
    int          rr;
    logic [15:0] used [64];
    int          nused = 0;

    always #5 clk = ~clk;

    meta_xlat_buf #(.GRAN_SHIFT(2)) uut (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_addr(lk_addr),
        .lk_hit(hit2), .lk_miss(miss2), .lk_maddr(ma2),
        .fill_en(fill_en), .fill_region(fill_region), .fill_base(fill_base),
        .inv_en(inv_en), .inv_region(inv_region), .flush(flush)
    );

    meta_xlat_buf #(.GRAN_SHIFT(3)) uut_g3 (
        .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_addr(lk_addr),
        .lk_hit(hit3), .lk_miss(miss3), .lk_maddr(ma3),
        .fill_en(fill_en), .fill_region(fill_region), .fill_base(fill_base),
        .inv_en(inv_en), .inv_region(inv_region), .flush(flush)
    );

    task automatic note_used(input logic [15:0] t);
        for (int i = 0; i < nused; i++) if (used[i] == t) return;
        if (nused < 64) begin
            used[nused] = t;
            nused++;
        end
    endtask

    task automatic check_lookup(input logic [31:0] a, input string req);
        logic        eh;
        logic [31:0] eb, e2, e3;
        @(negedge clk);
        lk_en = 1'b1;
        lk_addr = a;
        #2;
        eh = 1'b0;
        eb = '0;
        for (int i = 0; i < N; i++) begin
            if (mv[i] && mt[i] == a[31:16]) begin
                eh = 1'b1;
                eb = mb[i];
            end
        end
        e2 = eh ? eb + 32'(a[15:0] >> 2) : 32'h0;
        e3 = eh ? eb + 32'(a[15:0] >> 3) : 32'h0;
        total++;
        if (hit2 !== eh || miss2 !== !eh || ma2 !== e2) begin
            bad++;
            $display("FAIL %s addr=%h: hit=%b miss=%b maddr=%h expected hit=%b maddr=%h",
                     req, a, hit2, miss2, ma2, eh, e2);
        end
        total++;
        if (hit3 !== eh || miss3 !== !eh || ma3 !== e3) begin
            bad++;
            $display("FAIL R11 (%s) addr=%h: hit=%b maddr=%h expected hit=%b maddr=%h",
                     req, a, hit3, ma3, eh, e3);
        end
    endtask

    task automatic sweep(input string req);
        for (int u = 0; u < nused; u++) begin
            check_lookup({used[u], 16'h0000}, req);
            check_lookup({used[u], 16'h0007}, req);
            check_lookup({used[u], 16'hFFFF}, req);
        end
    endtask

    task automatic do_cycle(input bit fe, input logic [15:0] fr, input logic [31:0] fb,
                            input bit ie, input logic [15:0] ir, input bit fl);
        int  slot;
        bit  evict;
        slot = -1;
        evict = 1'b0;
        for (int i = N - 1; i >= 0; i--) if (!mv[i]) slot = i;
        for (int i = 0; i < N; i++) if (mv[i] && mt[i] == fr) slot = i;
        if (slot < 0) begin
            slot = rr;
            evict = 1'b1;
        end
        @(negedge clk);
        lk_en = 1'b0;
        fill_en = fe; fill_region = fr; fill_base = fb;
        inv_en = ie; inv_region = ir; flush = fl;
        @(posedge clk);
        #1;
        fill_en = 1'b0; inv_en = 1'b0; flush = 1'b0;
        if (ie) for (int i = 0; i < N; i++) if (mv[i] && mt[i] == ir) mv[i] = 1'b0;
        if (fe) begin
            mv[slot] = 1'b1; mt[slot] = fr; mb[slot] = fb;
            if (evict) rr = (rr + 1) % N;
            note_used(fr);
        end
        if (ie) note_used(ir);
        if (fl) begin
            for (int i = 0; i < N; i++) mv[i] = 1'b0;
            rr = 0;
        end
    endtask

    task automatic fill(input logic [15:0] r, input logic [31:0] b);
        do_cycle(1'b1, r, b, 1'b0, 16'h0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            mv[i] = 1'b0; mt[i] = '0; mb[i] = '0;
        end
        rr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R3: idle lookup port is quiet
        @(negedge clk);
        lk_en = 1'b0;
        lk_addr = 32'h1234_5678;
        #2;
        total++;
        if (hit2 !== 1'b0 || miss2 !== 1'b0 || ma2 !== 32'h0) begin
            bad++;
            $display("FAIL R3 idle: hit=%b miss=%b maddr=%h expected 0 0 0", hit2, miss2, ma2);
        end

        // R1: empty after reset
        check_lookup(32'h0000_0000, "R1");
        check_lookup(32'hABCD_1234, "R1");

        // R6: fill all entries with distinct regions; R2 sweep
        for (int t = 0; t < N; t++)
            fill(16'h1000 + 16'(t * 37), 32'h8000_0000 + 32'(t) * 32'h0001_0100);
        sweep("R2/R6");
        // R3: regions never installed
        check_lookup(32'h0000_4444, "R3");
        check_lookup(32'hFFFF_0000, "R3");

        // R4: fill visible the next cycle (overwrite of entry 3 also R5)
        fill(16'h1000 + 16'(3 * 37), 32'h4000_0000);
        check_lookup({16'h1000 + 16'(3 * 37), 16'h0123}, "R4");
        sweep("R5");

        // R7: full table, two new regions replace entries 0 and 1
        fill(16'h7000, 32'h9000_0000);
        fill(16'h7001, 32'h9100_0000);
        check_lookup({16'h1000, 16'h0010}, "R7");
        check_lookup({16'h1000 + 16'd37, 16'h0010}, "R7");
        sweep("R7");

        // R8: invalidate one held region, then one that is not held
        do_cycle(1'b0, 16'h0, 32'h0, 1'b1, 16'h1000 + 16'(6 * 37), 1'b0);
        do_cycle(1'b0, 16'h0, 32'h0, 1'b1, 16'h5555, 1'b0);
        sweep("R8");

        // R6 then R7: freed entry 6 reused, next new region evicts entry 2
        fill(16'h7002, 32'h9200_0000);
        fill(16'h7003, 32'h9300_0000);
        sweep("R6/R7");

        // R10: fill and invalidate of same region in one cycle
        do_cycle(1'b1, 16'h7002, 32'hA000_0000, 1'b1, 16'h7002, 1'b0);
        check_lookup({16'h7002, 16'h0040}, "R10");
        sweep("R10");

        // R9: flush overrides a same-cycle fill, pointer back to 0
        do_cycle(1'b1, 16'h7777, 32'hB000_0000, 1'b0, 16'h0, 1'b1);
        sweep("R9");
        check_lookup({16'h7777, 16'h0000}, "R9");
        for (int t = 0; t < N + 2; t++)
            fill(16'h2000 + 16'(t), 32'hC000_0000 + 32'(t) * 32'h100);
        sweep("R9");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule